// File: doc/BRIEF.md
# Digital Sample-Stream Trigger Detector

This block watches a stream of signed, already-digitized samples, at most one per clock and each marked by a valid strobe. It raises a one-cycle trigger pulse when a selected condition occurs. The block needs no analog comparator and no reference DAC. The supported conditions are:

- a rising crossing of a single level;
- a falling crossing of a single level;
- leaving a band bounded by a low and a high threshold;
- entering that band.

Every threshold comparison uses a shared hysteresis margin. A comparator state changes only when a sample clears the threshold by more than that margin, so noise near the threshold does not fire a trigger again and again.

The state of the single-level comparator is also output as a per-sample logic level with its own valid flag, for use by downstream serial decoders. An arm input gates only the trigger pulse. The comparators keep tracking the stream while the block is disarmed. The first valid sample after reset, or after any change to the configuration inputs, only seeds the comparator state and cannot fire a trigger.

Top module: `trig_detect`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, trig_pulse, logic_level and logic_valid are all 0.
- R2: In mode 2'b00 (rising), trig_pulse fires for a valid sample that moves the level comparator from 0 to 1.
- R3: In mode 2'b01 (falling), trig_pulse fires for a valid sample that moves the level comparator from 1 to 0.
- R4: A comparator sets only when the sample is strictly greater than threshold + hyst. It clears only when the sample is strictly less than threshold - hyst. Otherwise it holds. A sample exactly at a bound therefore leaves the state unchanged.
- R5: In mode 2'b10 (window exit), trig_pulse fires when the sample goes from inside the band to outside it. Inside means the low comparator is 1 and the high comparator is 0.
- R6: In mode 2'b11 (window entry), trig_pulse fires when the sample goes from outside the band to inside it.
- R7: In either window mode, when cfg_low is greater than cfg_high, trig_pulse never fires.
- R8: The first valid sample after reset, or after any change to a configuration input, sets each comparator to (sample > its threshold) and produces no trigger.
- R9: A valid sample that arrives while arm is 0 produces no trigger. It still updates the comparator states, which logic_level shows.
- R10: trig_pulse, logic_level and logic_valid reflect a sample one clock after its valid cycle. logic_valid is high for exactly that cycle, and trig_pulse is never high in two consecutive cycles.
- R11: Cycles with smp_valid low change no comparator state and produce trig_pulse = 0 and logic_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | W | Signed sample |
| arm | input | 1 | Trigger enable |
| cfg_mode | input | 2 | 00 rising, 01 falling, 10 window exit, 11 window entry |
| cfg_level | input | W | Signed single-crossing level |
| cfg_low | input | W | Signed lower band threshold |
| cfg_high | input | W | Signed upper band threshold |
| cfg_hyst | input | HW | Unsigned hysteresis margin |
| trig_pulse | output | 1 | One-cycle trigger |
| logic_level | output | 1 | Level comparator state |
| logic_valid | output | 1 | Strobe for logic_level |

## Verification
The hardest situation to reach is a sample that lands exactly on threshold ± hyst while the comparator already holds the opposite state. Reaching it needs an earlier sample that sets the state beyond the margin. The bench first sets the state with a sample well past the margin, then sends values exactly on the bound and one step past it.

Disarmed tracking cannot be seen from the trigger alone. The bench therefore crosses the level while disarmed, re-arms, and shows through logic_level, and through a following crossing that does not fire, that the state moved.

An inverted band is driven through samples that would cross both thresholds if the band were valid.

// File: rtl/trig_pkg.sv
package trig_pkg;

    typedef enum logic [1:0] {
        MODE_RISE  = 2'b00,
        MODE_FALL  = 2'b01,
        MODE_EXIT  = 2'b10,
        MODE_ENTRY = 2'b11
    } trig_mode_e;

    localparam int NCMP     = 3;
    localparam int CMP_MAIN = 0;
    localparam int CMP_LO   = 1;
    localparam int CMP_HI   = 2;

    typedef struct packed {
        logic cur;
        logic nxt;
    } cmp_pair_t;

    function automatic logic in_band(input logic lo_st, input logic hi_st, input logic ok);
        return ok & lo_st & ~hi_st;
    endfunction

    function automatic logic cond_hit(input trig_mode_e m, input cmp_pair_t lvl,
                                      input logic was_in, input logic now_in);
        case (m)
            MODE_RISE:  return ~lvl.cur & lvl.nxt;
            MODE_FALL:  return lvl.cur & ~lvl.nxt;
            MODE_EXIT:  return was_in & ~now_in;
            default:    return ~was_in & now_in;
        endcase
    endfunction

endpackage

// File: rtl/trig_cfg_watch.sv
module trig_cfg_watch #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic [CW-1:0] cfg_vec,
    output logic          primed
);
    logic [CW-1:0] snap_q;
    logic          primed_q;
    logic          changed;

    assign changed = (cfg_vec != snap_q);
    assign primed  = primed_q & ~changed;

    always_ff @(posedge clk) begin
        snap_q <= cfg_vec;
        if (rst)
            primed_q <= 1'b0;
        else if (smp_valid)
            primed_q <= 1'b1;
        else
            primed_q <= primed;
    end

    // R8
    seed_needs_sample_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(primed_q) |-> $past(smp_valid));

endmodule

// File: rtl/trig_hyst_cmp.sv
module trig_hyst_cmp #(
    parameter int W  = 12,
    parameter int HW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic                primed,
    input  logic signed [W-1:0] smp,
    input  logic signed [W-1:0] thr,
    input  logic [HW-1:0]       hyst,
    output trig_pkg::cmp_pair_t st
);
    localparam int EW = W + 2;

    logic signed [EW-1:0] smp_e, thr_e, hyst_e, up_b, dn_b;
    logic st_q, st_n;

    assign smp_e  = EW'(smp);
    assign thr_e  = EW'(thr);
    assign hyst_e = $signed({{(EW-HW){1'b0}}, hyst});
    assign up_b   = thr_e + hyst_e;
    assign dn_b   = thr_e - hyst_e;

    always_comb begin
        if (!primed)
            st_n = (smp_e > thr_e);
        else if (smp_e > up_b)
            st_n = 1'b1;
        else if (smp_e < dn_b)
            st_n = 1'b0;
        else
            st_n = st_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= 1'b0;
        else if (smp_valid)
            st_q <= st_n;
    end

    assign st.cur = st_q;
    assign st.nxt = st_n;

    // R11
    state_on_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != $past(st_q)) |-> $past(smp_valid));

    // R4
    set_above_band_chk: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && primed && smp_e > up_b) |=> st_q);

endmodule

// File: rtl/trig_cond.sv
module trig_cond (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic                primed,
    input  logic                arm,
    input  logic [1:0]          mode,
    input  logic                band_ok,
    input  trig_pkg::cmp_pair_t lvl,
    input  trig_pkg::cmp_pair_t lo,
    input  trig_pkg::cmp_pair_t hi,
    output logic                trig_pulse
);
    import trig_pkg::*;

    trig_mode_e m;
    logic was_in, now_in, hit;

    assign m      = trig_mode_e'(mode);
    assign was_in = in_band(lo.cur, hi.cur, band_ok);
    assign now_in = in_band(lo.nxt, hi.nxt, band_ok);
    assign hit    = smp_valid & primed & arm & cond_hit(m, lvl, was_in, now_in);

    always_ff @(posedge clk) begin
        if (rst)
            trig_pulse <= 1'b0;
        else
            trig_pulse <= hit;
    end

    // R7
    bad_band_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(band_ok || !mode[1]));

    // R9
    armed_primed_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(arm && smp_valid && primed));

endmodule

// File: rtl/trig_detect.sv
module trig_detect #(
    parameter int W  = 12,
    parameter int HW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic signed [W-1:0] smp_data,
    input  logic                arm,
    input  logic [1:0]          cfg_mode,
    input  logic signed [W-1:0] cfg_level,
    input  logic signed [W-1:0] cfg_low,
    input  logic signed [W-1:0] cfg_high,
    input  logic [HW-1:0]       cfg_hyst,
    output logic                trig_pulse,
    output logic                logic_level,
    output logic                logic_valid
);
    import trig_pkg::*;

    localparam int CW = 2 + 3 * W + HW;

    logic                primed;
    logic                band_ok;
    logic signed [W-1:0] thr_sel [NCMP];
    cmp_pair_t           cmp_st  [NCMP];

    trig_cfg_watch #(.CW(CW)) u_watch (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .cfg_vec   ({cfg_mode, cfg_level, cfg_low, cfg_high, cfg_hyst}),
        .primed    (primed)
    );

    assign thr_sel[CMP_MAIN] = cfg_level;
    assign thr_sel[CMP_LO]   = cfg_low;
    assign thr_sel[CMP_HI]   = cfg_high;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        trig_hyst_cmp #(.W(W), .HW(HW)) u_cmp (
            .clk       (clk),
            .rst       (rst),
            .smp_valid (smp_valid),
            .primed    (primed),
            .smp       (smp_data),
            .thr       (thr_sel[i]),
            .hyst      (cfg_hyst),
            .st        (cmp_st[i])
        );
    end

    assign band_ok = (cfg_low <= cfg_high);

    trig_cond u_cond (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .primed     (primed),
        .arm        (arm),
        .mode       (cfg_mode),
        .band_ok    (band_ok),
        .lvl        (cmp_st[CMP_MAIN]),
        .lo         (cmp_st[CMP_LO]),
        .hi         (cmp_st[CMP_HI]),
        .trig_pulse (trig_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst)
            logic_valid <= 1'b0;
        else
            logic_valid <= smp_valid;
    end

    assign logic_level = cmp_st[CMP_MAIN].cur;

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse);

    // R10
    pulse_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> logic_valid);

endmodule

// File: tb/trig_detect_tb.sv
module trig_detect_tb_top;
    localparam int W  = 12;
    localparam int HW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0;
    logic signed [W-1:0] smp_data = '0;
    logic arm = 1'b0;
    logic [1:0] cfg_mode = 2'b00;
    logic signed [W-1:0] cfg_level = '0, cfg_low = '0, cfg_high = '0;
    logic [HW-1:0] cfg_hyst = '0;
    logic trig_pulse, logic_level, logic_valid;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    trig_detect #(.W(W), .HW(HW)) dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data), .arm(arm),
        .cfg_mode(cfg_mode), .cfg_level(cfg_level), .cfg_low(cfg_low),
        .cfg_high(cfg_high), .cfg_hyst(cfg_hyst),
        .trig_pulse(trig_pulse), .logic_level(logic_level), .logic_valid(logic_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input int lvl, input int lo,
                           input int hi, input int h);
        @(negedge clk);
        cfg_mode  = m;
        cfg_level = W'(lvl);
        cfg_low   = W'(lo);
        cfg_high  = W'(hi);
        cfg_hyst  = HW'(h);
    endtask

    // drive one valid sample, check outputs one clock later (R10)
    task automatic send(input int d, input bit a, input bit et, input int el, input string tag);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = W'(d);
        arm       = a;
        @(negedge clk);
        smp_valid = 1'b0;
        chk({tag, " trig"}, int'(trig_pulse), int'(et));
        chk({tag, " R10 valid"}, int'(logic_valid), 1);
        if (el >= 0) chk({tag, " level"}, int'(logic_level), el);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 trig in reset", int'(trig_pulse), 0);
        chk("R1 level in reset", int'(logic_level), 0);
        chk("R1 valid in reset", int'(logic_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 trig after reset", int'(trig_pulse), 0);
        chk("R1 valid after reset", int'(logic_valid), 0);
    endtask

    task automatic t_rise();
        set_cfg(2'b00, 0, 0, 0, 10);
        do_reset();
        send(-50, 1, 0, 0, "R8 seed");
        send(5, 1, 0, 0, "R4 hold low");
        send(20, 1, 1, 1, "R2 rise");
        @(negedge clk);
        chk("R10 pulse width", int'(trig_pulse), 0);
        chk("R11 no valid", int'(logic_valid), 0);
        send(5, 1, 0, 1, "R4 hold high");
        send(-20, 1, 0, 0, "R2 fall ignored");
        send(15, 1, 1, 1, "R2 rise again");
    endtask

    task automatic t_fall_bounds();
        set_cfg(2'b01, 0, 0, 0, 10);
        send(50, 1, 0, 1, "R8 seed after cfg");
        send(-10, 1, 0, 1, "R4 exact lower bound");
        send(-11, 1, 1, 0, "R3 fall");
        send(10, 1, 0, 0, "R4 exact upper bound");
        send(11, 1, 0, 1, "R3 rise ignored");
    endtask

    task automatic t_exit();
        set_cfg(2'b10, 0, -100, 100, 5);
        send(0, 1, 0, 0, "R8 seed window");
        send(104, 1, 0, 1, "R4 high hold");
        send(106, 1, 1, 1, "R5 exit high");
        send(50, 1, 0, 1, "R5 reentry quiet");
        send(-106, 1, 1, 0, "R5 exit low");
    endtask

    task automatic t_entry();
        set_cfg(2'b11, 0, -100, 100, 5);
        send(200, 1, 0, 1, "R8 seed outside");
        send(90, 1, 1, -1, "R6 entry");
        send(300, 1, 0, -1, "R6 exit quiet");
        send(0, 1, 1, -1, "R6 entry again");
    endtask

    task automatic t_bad_band();
        set_cfg(2'b11, 0, 100, -100, 0);
        send(0, 1, 0, -1, "R7 seed");
        send(200, 1, 0, -1, "R7 high");
        send(0, 1, 0, -1, "R7 back");
        send(-200, 1, 0, -1, "R7 low");
        send(0, 1, 0, -1, "R7 back");
        set_cfg(2'b10, 0, 100, -100, 0);
        send(0, 1, 0, -1, "R7 seed exit");
        send(200, 1, 0, -1, "R7 exit high");
        send(-200, 1, 0, -1, "R7 exit low");
    endtask

    task automatic t_arm_invalid();
        set_cfg(2'b00, 0, 0, 0, 10);
        send(-50, 1, 0, 0, "R8 seed");
        send(50, 0, 0, 1, "R9 disarmed tracks");
        send(60, 1, 0, 1, "R9 no late fire");
        send(-50, 1, 0, 0, "R9 clear");
        send(50, 1, 1, 1, "R9 armed fire");
        @(negedge clk);
        smp_valid = 1'b0;
        smp_data  = W'(-500);
        repeat (3) @(negedge clk);
        chk("R11 trig idle", int'(trig_pulse), 0);
        chk("R11 level held", int'(logic_level), 1);
        send(50, 1, 0, 1, "R11 invalid ignored");
    endtask

    task automatic t_cfg_reseed();
        cfg_hyst = HW'(10);
        send(-50, 1, 0, 0, "R2 set low");
        set_cfg(2'b00, 0, 0, 0, 11);
        send(50, 1, 0, 1, "R8 cfg change seeds");
        send(-50, 1, 0, 0, "R8 clear");
        send(50, 1, 1, 1, "R8 rise after seed");
        do_reset();
        send(50, 1, 0, 1, "R8 seed after reset");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        t_rise();
        t_fall_bounds();
        t_exit();
        t_entry();
        t_bad_band();
        t_arm_invalid();
        t_cfg_reseed();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule